// File: doc/BRIEF.md
# Two-Phase Scan Sequencer

This block runs one scan operation on a design built from latches and domino stages. On a start request it stops the functional clock in its low state, then forces the scan-gated evaluation clock low. It then marches data along the scan chain by alternating two nonoverlapping scan clocks. The first scan clock copies each cell's content into its scan stage, toward scan-out. The second writes the upstream scan stage, or the serial input at the head, into the cell. When the programmed number of steps is done, the functional clock restarts. The gated clock stays low for a short precharge window, is then released, and a done pulse marks the end.

A small behavioural chain of scan cells sits inside the block so the sequence can be observed end to end. While the functional clock runs, each cell captures its functional data every cycle. While the clock is stopped, the cells only move through the scan path. The sequencer is meant to sit beside the clock generator. Its outputs are level controls that do not need tight timing, and the functional clocks need only a stop and a gate-low control.

Top module: `scan_seq_top`

## Requirements
- R1: While reset is high, clk_stop_o, gate_low_o, sca_o, scb_o and done_o are 0. Every cell and scan stage is 0, so chain_q_o is all zeros and scan_out_o is 0.
- R2: A start request sampled while idle raises clk_stop_o on the next cycle. gate_low_o rises one cycle later. Both stay high through all shifting.
- R3: sca_o and scb_o are high only while clk_stop_o and gate_low_o are both high, and never at the same time. Each step is sca_o high for PULSE_CYC cycles, GAP_CYC dead cycles, scb_o high for PULSE_CYC cycles, then GAP_CYC dead cycles.
- R4: The number of steps equals shift_len_i as sampled with the accepted start. A count of 0 gives no scan clock pulse at all.
- R5: A cycle with sca_o high copies each cell into its own scan stage. scan_out_o always shows the scan stage of the last cell, bit N_CELLS-1.
- R6: A cycle with scb_o high loads cell i from scan stage i-1, and cell 0 from scan_in_i. After N_CELLS steps the old content has left through scan_out_o, last cell first, and the chain holds the scan-in bits.
- R7: After the last dead gap, clk_stop_o falls while gate_low_o stays high for PRE_CYC cycles. Then gate_low_o falls and done_o is high for exactly that one cycle.
- R8: A start request in any cycle from the first clock-stop cycle through the done cycle is ignored. No second operation follows it.
- R9: While clk_stop_o is low, every cell loads its bit of func_d_i each cycle. While clk_stop_o is high, func_d_i has no effect on the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one scan operation |
| shift_len_i | input | LEN_W | Number of shift steps, sampled at start |
| scan_in_i | input | 1 | Serial data entering cell 0 |
| func_d_i | input | N_CELLS | Functional data captured while the clock runs |
| clk_stop_o | output | 1 | Functional clock held low |
| gate_low_o | output | 1 | Scan-gated evaluation clock forced low |
| sca_o | output | 1 | Scan clock A: cell to scan stage |
| scb_o | output | 1 | Scan clock B: scan stage into next cell |
| done_o | output | 1 | One-cycle pulse after the gated clock is released |
| scan_out_o | output | 1 | Scan stage of the last cell |
| chain_q_o | output | N_CELLS | Content of the model chain cells |

## Verification
The bench covers a zero-length operation. A sequencer that did not test the count before the first step would emit one stray pulse pair there, or wrap the counter and shift many times. It also covers a count longer than the chain, where scan-in bits must come out of scan_out_o after the original content. Start requests are raised during an operation and held high through back-to-back operations. A design that re-armed from any state but idle would start a second sequence or lengthen the current one. With a dead gap of two cycles and a two-cycle precharge window, an off-by-one in the gap timer or release order shifts every later edge. Random functional data applied while stopped exposes a chain that still captures functional data during scan.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_STOP,
        ST_GATE,
        ST_SCA,
        ST_GAP_A,
        ST_SCB,
        ST_GAP_B,
        ST_RESTART,
        ST_RELEASE
    } seq_state_t;

    typedef struct packed {
        logic stop;
        logic gate;
        logic sca;
        logic scb;
        logic done;
    } scan_ctl_t;

    function automatic scan_ctl_t ctl_of(seq_state_t s);
        scan_ctl_t c;
        c = '0;
        case (s)
            ST_STOP:    c.stop = 1'b1;
            ST_GATE,
            ST_GAP_A,
            ST_GAP_B:   begin c.stop = 1'b1; c.gate = 1'b1; end
            ST_SCA:     begin c.stop = 1'b1; c.gate = 1'b1; c.sca = 1'b1; end
            ST_SCB:     begin c.stop = 1'b1; c.gate = 1'b1; c.scb = 1'b1; end
            ST_RESTART: c.gate = 1'b1;
            ST_RELEASE: c.done = 1'b1;
            default:    c = '0;
        endcase
        return c;
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
    import scan_seq_pkg::*;
#(
    parameter int unsigned LEN_W     = 5,
    parameter int unsigned PULSE_CYC = 1,
    parameter int unsigned GAP_CYC   = 1,
    parameter int unsigned PRE_CYC   = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [LEN_W-1:0] shift_len_i,
    output scan_ctl_t        ctl_o
);
    localparam int unsigned LONGEST = max3(PULSE_CYC, GAP_CYC, PRE_CYC);
    localparam int unsigned TW      = $clog2(LONGEST + 1);
    localparam logic [TW-1:0] PULSE_LD = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0] GAP_LD   = TW'(GAP_CYC - 1);
    localparam logic [TW-1:0] PRE_LD   = TW'(PRE_CYC - 1);

    seq_state_t       state, state_n;
    logic [TW-1:0]    cnt, cnt_n;
    logic [LEN_W-1:0] steps, steps_n;
    logic             cnt_zero;

    assign cnt_zero = (cnt == '0);

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        steps_n = steps;
        case (state)
            ST_IDLE: if (start_i) begin
                steps_n = shift_len_i;
                state_n = ST_STOP;
            end
            ST_STOP: state_n = ST_GATE;
            ST_GATE: if (steps == '0) begin
                state_n = ST_RESTART;
                cnt_n   = PRE_LD;
            end else begin
                state_n = ST_SCA;
                cnt_n   = PULSE_LD;
            end
            ST_SCA: if (!cnt_zero) cnt_n = cnt - TW'(1);
                    else begin state_n = ST_GAP_A; cnt_n = GAP_LD; end
            ST_GAP_A: if (!cnt_zero) cnt_n = cnt - TW'(1);
                      else begin state_n = ST_SCB; cnt_n = PULSE_LD; end
            ST_SCB: if (!cnt_zero) cnt_n = cnt - TW'(1);
                    else begin state_n = ST_GAP_B; cnt_n = GAP_LD; end
            ST_GAP_B: if (!cnt_zero) cnt_n = cnt - TW'(1);
                else begin
                    steps_n = steps - LEN_W'(1);
                    if (steps == LEN_W'(1)) begin
                        state_n = ST_RESTART;
                        cnt_n   = PRE_LD;
                    end else begin
                        state_n = ST_SCA;
                        cnt_n   = PULSE_LD;
                    end
                end
            ST_RESTART: if (!cnt_zero) cnt_n = cnt - TW'(1);
                        else state_n = ST_RELEASE;
            ST_RELEASE: state_n = ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            steps <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            steps <= steps_n;
        end
    end

    assign ctl_o = ctl_of(state);

endmodule

// File: rtl/scan_cell.sv
module scan_cell (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic func_d_i,
    input  logic sca_i,
    input  logic scb_i,
    input  logic prev_i,
    output logic q_o,
    output logic sq_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_o  <= 1'b0;
            sq_o <= 1'b0;
        end else begin
            if (run_i)      q_o <= func_d_i;
            else if (scb_i) q_o <= prev_i;
            if (sca_i)      sq_o <= q_o;
        end
    end
endmodule

// File: rtl/scan_chain.sv
module scan_chain #(
    parameter int unsigned N_CELLS = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run_i,
    input  logic               sca_i,
    input  logic               scb_i,
    input  logic               scan_in_i,
    input  logic [N_CELLS-1:0] func_d_i,
    output logic [N_CELLS-1:0] q_o,
    output logic               scan_out_o
);
    logic [N_CELLS-1:0] sq;
    logic [N_CELLS:0]   link;

    assign link[0] = scan_in_i;

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        scan_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .run_i    (run_i),
            .func_d_i (func_d_i[i]),
            .sca_i    (sca_i),
            .scb_i    (scb_i),
            .prev_i   (link[i]),
            .q_o      (q_o[i]),
            .sq_o     (sq[i])
        );
        assign link[i+1] = sq[i];
    end

    assign scan_out_o = link[N_CELLS];
endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top
    import scan_seq_pkg::*;
#(
    parameter int unsigned N_CELLS   = 8,
    parameter int unsigned LEN_W     = 5,
    parameter int unsigned PULSE_CYC = 1,
    parameter int unsigned GAP_CYC   = 1,
    parameter int unsigned PRE_CYC   = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [LEN_W-1:0]   shift_len_i,
    input  logic               scan_in_i,
    input  logic [N_CELLS-1:0] func_d_i,
    output logic               clk_stop_o,
    output logic               gate_low_o,
    output logic               sca_o,
    output logic               scb_o,
    output logic               done_o,
    output logic               scan_out_o,
    output logic [N_CELLS-1:0] chain_q_o
);
    scan_ctl_t ctl;

    scan_seq_ctrl #(
        .LEN_W     (LEN_W),
        .PULSE_CYC (PULSE_CYC),
        .GAP_CYC   (GAP_CYC),
        .PRE_CYC   (PRE_CYC)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .shift_len_i (shift_len_i),
        .ctl_o       (ctl)
    );

    scan_chain #(
        .N_CELLS (N_CELLS)
    ) u_chain (
        .clk        (clk),
        .rst        (rst),
        .run_i      (!ctl.stop),
        .sca_i      (ctl.sca),
        .scb_i      (ctl.scb),
        .scan_in_i  (scan_in_i),
        .func_d_i   (func_d_i),
        .q_o        (chain_q_o),
        .scan_out_o (scan_out_o)
    );

    assign clk_stop_o = ctl.stop;
    assign gate_low_o = ctl.gate;
    assign sca_o      = ctl.sca;
    assign scb_o      = ctl.scb;
    assign done_o     = ctl.done;
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk (
    input logic clk,
    input logic rst,
    input logic stop,
    input logic gate,
    input logic sca,
    input logic scb,
    input logic done
);
    AST_SCAN_WHILE_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (sca || scb) |-> (stop && gate)); // R3
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(sca && scb)); // R3
    AST_GAP_AFTER_A: assert property (@(posedge clk) disable iff (rst)
        $fell(sca) |-> !scb); // R3
    AST_GAP_AFTER_B: assert property (@(posedge clk) disable iff (rst)
        $fell(scb) |-> !sca); // R3
    AST_STOP_BEFORE_GATE: assert property (@(posedge clk) disable iff (rst)
        $rose(gate) |-> $past(stop)); // R2
    AST_STOP_ALONE_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(stop) |-> !gate); // R2
    AST_RELEASE_AFTER_RESTART: assert property (@(posedge clk) disable iff (rst)
        $fell(gate) |-> !stop); // R7
    AST_DONE_ORDER: assert property (@(posedge clk) disable iff (rst)
        done |-> (!stop && !gate && $past(gate))); // R7
endmodule

bind scan_seq_top scan_seq_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .stop (clk_stop_o),
    .gate (gate_low_o),
    .sca  (sca_o),
    .scb  (scb_o),
    .done (done_o)
);

// File: tb/sim_scan_seq_top.sv
module sim_scan_seq_top;
    localparam int CLK_PERIOD = 10;
    localparam int N     = 8;
    localparam int LW    = 5;
    localparam int PULSE = 1;
    localparam int GAP   = 2;
    localparam int PRE   = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [LW-1:0] shift_len_i = '0;
    logic          scan_in_i = 1'b0;
    logic [N-1:0]  func_d_i = '0;
    logic          clk_stop_o, gate_low_o, sca_o, scb_o, done_o, scan_out_o;
    logic [N-1:0]  chain_q_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scan_seq_top #(
        .N_CELLS (N), .LEN_W (LW), .PULSE_CYC (PULSE), .GAP_CYC (GAP), .PRE_CYC (PRE)
    ) u0 (
        .clk (clk), .rst (rst), .start_i (start_i), .shift_len_i (shift_len_i),
        .scan_in_i (scan_in_i), .func_d_i (func_d_i),
        .clk_stop_o (clk_stop_o), .gate_low_o (gate_low_o), .sca_o (sca_o),
        .scb_o (scb_o), .done_o (done_o), .scan_out_o (scan_out_o), .chain_q_o (chain_q_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model: expected {stop, gate, sca, scb, done} per cycle
    logic [4:0]   exp_q[$];
    logic [N-1:0] md = '0;
    logic [N-1:0] ms = '0;
    int           pulses = 0;
    int           op_len = 0;
    logic         prev_sca = 1'b0;

    task automatic push_op(input int len);
        exp_q.push_back(5'b10000);
        exp_q.push_back(5'b11000);
        for (int s = 0; s < len; s++) begin
            repeat (PULSE) exp_q.push_back(5'b11100);
            repeat (GAP)   exp_q.push_back(5'b11000);
            repeat (PULSE) exp_q.push_back(5'b11010);
            repeat (GAP)   exp_q.push_back(5'b11000);
        end
        repeat (PRE) exp_q.push_back(5'b01000);
        exp_q.push_back(5'b00001);
    endtask

    always @(negedge clk) begin
        logic [4:0]   e;
        logic [N-1:0] old_md;
        bit           was_idle;
        if (rst) begin
            exp_q.delete();
            md = '0;
            ms = '0;
            pulses = 0;
            prev_sca = 1'b0;
        end else begin
            e = (exp_q.size() != 0) ? exp_q[0] : 5'b00000;
            chk(clk_stop_o == e[4], "R2 clk_stop", 32'(clk_stop_o), 32'(e[4]));
            chk(gate_low_o == e[3], "R2 gate_low", 32'(gate_low_o), 32'(e[3]));
            chk(sca_o == e[2], "R3 sca", 32'(sca_o), 32'(e[2]));
            chk(scb_o == e[1], "R3 scb", 32'(scb_o), 32'(e[1]));
            chk(done_o == e[0], "R7 done", 32'(done_o), 32'(e[0]));
            chk(chain_q_o == md, "R6/R9 chain", 32'(chain_q_o), 32'(md));
            chk(scan_out_o == ms[N-1], "R5 scan_out", 32'(scan_out_o), 32'(ms[N-1]));
            if (sca_o && !prev_sca) pulses++;
            prev_sca = sca_o;
            if (done_o) begin
                chk(pulses == op_len, "R4 pulse count", 32'(pulses), 32'(op_len));
                pulses = 0;
            end
            was_idle = (exp_q.size() == 0);
            if (!was_idle) void'(exp_q.pop_front());
            old_md = md;
            if (!e[4])     md = func_d_i;
            else if (e[1]) md = {ms[N-2:0], scan_in_i};
            if (e[2])      ms = old_md;
            if (was_idle && start_i) begin
                op_len = int'(shift_len_i);
                push_op(op_len);
            end
        end
    end

    // free-running stimulus on data inputs
    initial begin
        logic [15:0] lf;
        lf = 16'hACE1;
        forever begin
            @(posedge clk);
            #1;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            func_d_i  = lf[N-1:0];
            scan_in_i = lf[9];
        end
    end

    task automatic wait_done();
        do @(negedge clk); while (!done_o);
    endtask

    task automatic do_op(input int len, input bit mid);
        @(posedge clk); #1;
        start_i = 1'b1;
        shift_len_i = LW'(len);
        @(posedge clk); #1;
        start_i = 1'b0;
        if (mid) begin
            repeat (3) @(posedge clk);
            #1 start_i = 1'b1;
            shift_len_i = LW'(7);
            repeat (2) @(posedge clk);
            #1 start_i = 1'b0;
        end
        wait_done();
        repeat (3) begin
            @(negedge clk);
            chk(clk_stop_o == 1'b0, "R8 no restart after ignored start", 32'(clk_stop_o), 32'h0);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R2: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({clk_stop_o, gate_low_o, sca_o, scb_o, done_o} == 5'b0, "R1 controls in reset",
            32'({clk_stop_o, gate_low_o, sca_o, scb_o, done_o}), 32'h0);
        chk(chain_q_o == '0 && scan_out_o == 1'b0, "R1 chain in reset",
            32'({chain_q_o, scan_out_o}), 32'h0);
        @(posedge clk); #1 rst = 1'b0;
        repeat (4) @(posedge clk);
        do_op(N, 1'b0);      // full read-out and load
        do_op(0, 1'b0);      // zero-length, no pulses
        do_op(3, 1'b1);      // partial shift with ignored start
        do_op(N + 3, 1'b0);  // longer than the chain
        do_op(1, 1'b1);      // single step with ignored start
        @(posedge clk); #1;
        start_i = 1'b1;      // held high: back-to-back operations
        shift_len_i = LW'(2);
        wait_done();
        wait_done();
        @(posedge clk); #1 start_i = 1'b0;
        repeat (6) @(negedge clk);
        chk(clk_stop_o == 1'b0, "R8 idle after held start dropped", 32'(clk_stop_o), 32'h0);
        finish_run();
    end
endmodule